// File: doc/BRIEF.md
# CAN Message Object Control-State Updater

This block holds the control state of a bank of CAN message objects. For each object it keeps a valid flag, a transmit-request flag, a direction bit, a FIFO membership bit and three mode bits. It applies the changes that follow from the protocol engine's "transmission started" and "transfer completed successfully" events. Each event carries the object index. A completion event also says whether the frame was a data frame or a remote frame. An object with direction 1 sends data frames and receives remote frames. An object with direction 0 does the reverse. A completion therefore counts as a transmission exactly when the direction bit differs from the remote flag.

Objects can be chained into a FIFO that is led by a base object. Each member names its base. The base holds a lower and an upper element index and a pointer to the element currently in use. The base's FIFO-direction mode bit selects whether the pointer moves on receptions or on transmissions. A second mode bit clears the valid flag after a data transfer. A third mode bit drops the transmit request as soon as transmission starts, so a failed attempt is not retried. Software programs everything through a single write port and reads back one object at a time.

Top module: `can_mobj_ctrl`

## Requirements
- R1: After reset, every valid and transmit-request flag is 0, every pointer, bound and base link is 0, and cfg_err is low.
- R2: A write with wr_sel=0 loads the control word of object wr_idx. The bit order is bit0 valid, bit1 transmit request, bit2 direction, bit3 FIFO direction, bit4 single data transfer, bit5 single transmission try, bit6 FIFO member. The word reads back on rd_ctrl for rd_idx. wr_sel=1 loads the base link from wr_data[IDX_W-1:0]. wr_sel=2 loads the lower bound from wr_data[IDX_W-1:0] and the upper bound from wr_data[2*IDX_W-1:IDX_W]. wr_sel=3 loads the pointer from wr_data[IDX_W-1:0]. rd_ptr shows the pointer of rd_idx.
- R3: A completion counts as a transmission when the object's direction bit XOR done_remote is 1, and as a reception otherwise.
- R4: When a base has FIFO direction 0, its pointer advances after a successful reception by the member it currently points to. A transmission by that member leaves the pointer unchanged.
- R5: When a base has FIFO direction 1, its pointer advances after a successful transmission by the member it currently points to. A reception leaves the pointer unchanged.
- R6: An advance from the upper bound wraps to the lower bound. Otherwise the pointer increments by one. A completion by a member that the pointer does not address leaves the pointer unchanged.
- R7: After a successful data-frame transfer in either direction, the valid flag clears when single data transfer is 1 and stays unchanged when it is 0.
- R8: A successful remote-frame transfer never changes the valid flag, whatever the single data transfer bit is.
- R9: With single transmission try 1, the transmit request clears in the cycle after the start event. With it at 0, a start leaves the request pending. A successful transmission always clears it.
- R10: cfg_err is high while any FIFO member has single data transfer set.
- R11: When a register write and a hardware clear hit the same flag in the same cycle, the flag ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Object index written |
| wr_sel | input | 2 | Field select of the write |
| wr_data | input | WR_W | Write data |
| start_vld | input | 1 | Transmission started event |
| start_idx | input | IDX_W | Object of the start event |
| done_vld | input | 1 | Transfer completed successfully event |
| done_idx | input | IDX_W | Object of the completion event |
| done_remote | input | 1 | Completed frame was a remote frame |
| rd_idx | input | IDX_W | Object shown on the read outputs |
| rd_ctrl | output | 7 | Control word of rd_idx |
| rd_ptr | output | IDX_W | FIFO pointer of rd_idx |
| valid_o | output | NUM_OBJ | Valid flags of all objects |
| txreq_o | output | NUM_OBJ | Transmit-request flags of all objects |
| cfg_err | output | 1 | A FIFO member has single data transfer set |

## Verification
Assertions check on every cycle the flag rules that depend on a single object. A start with single transmission try set drops the request. A start without it keeps the request. A data completion with single data transfer set clears valid. A remote completion leaves valid alone. The FIFO pointer rules (direction selection, the addressed-member condition and the wrap from upper to lower bound) and the configuration check need a set of programmed objects. Write-versus-hardware collisions need the same too. Only the bench's scenarios can show these.

// File: rtl/can_mobj_ctrl.sv
module can_mobj_ctrl #(
  parameter int NUM_OBJ = 8,
  parameter int IDX_W   = $clog2(NUM_OBJ),
  parameter int WR_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [1:0]         wr_sel,
  input  logic [WR_W-1:0]    wr_data,
  input  logic               start_vld,
  input  logic [IDX_W-1:0]   start_idx,
  input  logic               done_vld,
  input  logic [IDX_W-1:0]   done_idx,
  input  logic               done_remote,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [6:0]         rd_ctrl,
  output logic [IDX_W-1:0]   rd_ptr,
  output logic [NUM_OBJ-1:0] valid_o,
  output logic [NUM_OBJ-1:0] txreq_o,
  output logic               cfg_err
);

  logic [NUM_OBJ-1:0] valid_q, txreq_q, dir_q, fdir_q, sdt_q, stt_q, memb_q;
  logic [IDX_W-1:0]   base_q [NUM_OBJ];
  logic [IDX_W-1:0]   lo_q   [NUM_OBJ];
  logic [IDX_W-1:0]   hi_q   [NUM_OBJ];
  logic [IDX_W-1:0]   ptr_q  [NUM_OBJ];

  logic             done_tx, adv;
  logic [IDX_W-1:0] dbase, ptr_nxt;
  logic             unused_bits;

  assign done_tx = dir_q[done_idx] ^ done_remote;
  assign dbase   = base_q[done_idx];
  assign adv     = done_vld && memb_q[done_idx] && (fdir_q[dbase] == done_tx)
                   && (ptr_q[dbase] == done_idx);
  assign ptr_nxt = (ptr_q[dbase] == hi_q[dbase]) ? lo_q[dbase] : ptr_q[dbase] + 1'b1;

  assign valid_o     = valid_q;
  assign txreq_o     = txreq_q;
  assign cfg_err     = |(memb_q & sdt_q);
  assign rd_ptr      = ptr_q[rd_idx];
  assign rd_ctrl     = {memb_q[rd_idx], stt_q[rd_idx], sdt_q[rd_idx], fdir_q[rd_idx],
                        dir_q[rd_idx], txreq_q[rd_idx], valid_q[rd_idx]};
  assign unused_bits = ^wr_data[WR_W-1:7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0; txreq_q <= '0; dir_q <= '0; fdir_q <= '0;
      sdt_q   <= '0; stt_q   <= '0; memb_q <= '0;
      for (int i = 0; i < NUM_OBJ; i++) begin
        base_q[i] <= '0; lo_q[i] <= '0; hi_q[i] <= '0; ptr_q[i] <= '0;
      end
    end else begin
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin
            valid_q[wr_idx] <= wr_data[0];
            txreq_q[wr_idx] <= wr_data[1];
            dir_q[wr_idx]   <= wr_data[2];
            fdir_q[wr_idx]  <= wr_data[3];
            sdt_q[wr_idx]   <= wr_data[4];
            stt_q[wr_idx]   <= wr_data[5];
            memb_q[wr_idx]  <= wr_data[6];
          end
          2'd1: base_q[wr_idx] <= wr_data[IDX_W-1:0];
          2'd2: begin
            lo_q[wr_idx] <= wr_data[IDX_W-1:0];
            hi_q[wr_idx] <= wr_data[2*IDX_W-1:IDX_W];
          end
          default: ptr_q[wr_idx] <= wr_data[IDX_W-1:0];
        endcase
      end
      // hardware updates come last so they override a same-cycle write (R11)
      if (start_vld && stt_q[start_idx]) txreq_q[start_idx] <= 1'b0;
      if (done_vld && done_tx) txreq_q[done_idx] <= 1'b0;
      if (done_vld && !done_remote && sdt_q[done_idx]) valid_q[done_idx] <= 1'b0;
      if (adv) ptr_q[dbase] <= ptr_nxt;
    end
  end

  a_r9_stt_drop: assert property (@(posedge clk) disable iff (!rst_n)
    start_vld && stt_q[start_idx] |=> !txreq_o[$past(start_idx)]);

  a_r9_no_stt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    start_vld && !stt_q[start_idx] && !(done_vld && done_idx == start_idx)
    && !(wr_en && wr_sel == 2'd0 && wr_idx == start_idx)
    |=> txreq_o[$past(start_idx)] == $past(txreq_o[start_idx]));

  a_r7_sdt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld && !done_remote && sdt_q[done_idx] |=> !valid_o[$past(done_idx)]);

  a_r8_remote_keep: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld && done_remote && !(wr_en && wr_sel == 2'd0 && wr_idx == done_idx)
    |=> valid_o[$past(done_idx)] == $past(valid_o[done_idx]));

endmodule

// File: tb/test_can_mobj_ctrl.sv
module test_can_mobj_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, start_vld = 1'b0, done_vld = 1'b0, done_remote = 1'b0;
  logic [IW-1:0] wr_idx = '0, start_idx = '0, done_idx = '0, rd_idx = '0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [6:0] rd_ctrl;
  logic [IW-1:0] rd_ptr;
  logic [N-1:0] valid_o, txreq_o;
  logic cfg_err;
  int n_chk = 0, n_fail = 0;

  // {dir, remote, sdt, expected valid, expected txreq}
  localparam logic [4:0] VEC [8] = '{5'b00011, 5'b00101, 5'b01010, 5'b01110,
                                     5'b10010, 5'b10100, 5'b11011, 5'b11111};

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mobj_ctrl #(.NUM_OBJ(N), .IDX_W(IW), .WR_W(8)) i_can_mobj_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
    .wr_data(wr_data), .start_vld(start_vld), .start_idx(start_idx),
    .done_vld(done_vld), .done_idx(done_idx), .done_remote(done_remote),
    .rd_idx(rd_idx), .rd_ctrl(rd_ctrl), .rd_ptr(rd_ptr), .valid_o(valid_o),
    .txreq_o(txreq_o), .cfg_err(cfg_err));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_sel = 2'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done(input int idx, input bit rem);
    @(negedge clk);
    done_vld = 1'b1; done_idx = IW'(idx); done_remote = rem;
    @(negedge clk);
    done_vld = 1'b0;
  endtask

  task automatic start(input int idx);
    @(negedge clk);
    start_vld = 1'b1; start_idx = IW'(idx);
    @(negedge clk);
    start_vld = 1'b0;
  endtask

  task automatic chk_ptr(input string req, input int base, input int exp);
    rd_idx = IW'(base); #1;
    check(req, int'(rd_ptr), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 valid", int'(valid_o), 0);
    check("R1 txreq", int'(txreq_o), 0);
    check("R1 cfg_err", int'(cfg_err), 0);
    chk_ptr("R1 ptr", 0, 0);

    wr(3, 0, 'h2A);
    rd_idx = 3; #1;
    check("R2 ctrl readback", int'(rd_ctrl), 'h2A);
    wr(3, 3, 5);
    chk_ptr("R2 ptr readback", 3, 5);

    // table walk: object 1, R3 R7 R8 R9 completion rules
    for (int k = 0; k < 8; k++) begin
      logic [4:0] v;
      v = VEC[k];
      wr(1, 0, (int'(v[2]) << 4) | (int'(v[4]) << 2) | 3);
      done(1, v[3]);
      #1;
      check($sformatf("R7/R8 valid vec%0d", k), int'(valid_o[1]), int'(v[1]));
      check($sformatf("R3/R9 txreq vec%0d", k), int'(txreq_o[1]), int'(v[0]));
    end

    // FIFO: base 4, members 4..6, receive direction
    for (int m = 4; m <= 6; m++) begin
      wr(m, 0, 'h41);
      wr(m, 1, 4);
    end
    wr(4, 2, (6 << 3) | 4);
    wr(4, 3, 4);
    done(4, 1'b0);
    chk_ptr("R4 rx advances", 4, 5);
    done(6, 1'b0);
    chk_ptr("R6 non-addressed member", 4, 5);
    done(5, 1'b1);
    chk_ptr("R4 tx ignored", 4, 5);
    done(5, 1'b0);
    chk_ptr("R4 rx advances again", 4, 6);
    done(6, 1'b0);
    chk_ptr("R6 wrap to lower bound", 4, 4);
    wr(4, 0, 'h49);
    done(4, 1'b0);
    chk_ptr("R5 rx ignored", 4, 4);
    done(4, 1'b1);
    chk_ptr("R5 tx advances", 4, 5);

    check("R10 clean config", int'(cfg_err), 0);
    wr(5, 0, 'h51);
    #1 check("R10 member with sdt", int'(cfg_err), 1);
    wr(5, 0, 'h41);
    #1 check("R10 cleared", int'(cfg_err), 0);

    wr(2, 0, 'h23);
    start(2);
    #1 check("R9 stt drops at start", int'(txreq_o[2]), 0);
    wr(2, 0, 'h07);
    start(2);
    #1 check("R9 no stt keeps request", int'(txreq_o[2]), 1);
    done(2, 1'b0);
    #1 check("R9 tx completion clears", int'(txreq_o[2]), 0);

    @(negedge clk);
    wr_en = 1'b1; wr_idx = 1; wr_sel = 0; wr_data = 'h17;
    done_vld = 1'b1; done_idx = 1; done_remote = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; done_vld = 1'b0;
    #1;
    check("R11 valid clear wins", int'(valid_o[1]), 0);
    check("R11 txreq clear wins", int'(txreq_o[1]), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule